// File: doc/BRIEF.md
# Reset Sequencing Controller

This block turns two active-low reset requests, a power-on request and a warm request, into three active-low reset outputs. The first goes to the on-chip modules, the second to the test-access port logic and the third to the system's external devices. Each output drops as soon as its request drops, with no clock needed. Each output rises only through a synchroniser on the reference clock, so every module driven from the module reset leaves reset on the same clock edge.

A warm request resets the modules and the external devices but leaves the test-access reset alone. The external reset is not released by a timer. It stays low until software writes a 1 to the release bit of a control register through a plain write port. Any later reset clears that bit again. A two-bit cause field records whether the last reset was power-on or warm, so software can read why the system came up.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n` is low, `mod_rst_n`, `jtag_rst_n` and `ext_rst_n` are all low, and they go low without waiting for a clock edge.
- R2: While `warm_n` is low and `por_n` is high, `mod_rst_n` and `ext_rst_n` are low and `jtag_rst_n` keeps its value.
- R3: `mod_rst_n` goes high on the second rising clock edge after both inputs are high. `jtag_rst_n` goes high on the second rising edge after `por_n` is high.
- R4: After `mod_rst_n` goes high, `ext_rst_n` stays low until a write with `wr_addr` = 0 and `wr_data` bit 0 = 1. It goes high on the clock edge that takes that write.
- R5: A write to any other address, or a write to address 0 with bit 0 = 0, does not change `ext_rst_n`. Once released, `ext_rst_n` stays high until the next reset.
- R6: Every power-on or warm reset clears the release bit. After such a reset, `ext_rst_n` stays low after `mod_rst_n` goes high.
- R7: `cause` reads 00 while a power-on reset is held. One clock edge after `mod_rst_n` goes high it reads 01 if that reset began with a power-on request, or 10 if it was warm only. A warm reset leaves the old value in place until then. The value 11 never appears.
- R8: When both inputs are low together, the block acts as for a power-on reset: `jtag_rst_n` is low and `cause` ends up 01.
- R9: Writes made while `mod_rst_n` is low are ignored and do not release `ext_rst_n` later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| warm_n | input | 1 | Warm reset request, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| mod_rst_n | output | 1 | Module reset, active low |
| jtag_rst_n | output | 1 | Test-access reset, active low |
| ext_rst_n | output | 1 | External system reset, active low |
| cause | output | 2 | Last reset kind: 00 none, 01 power-on, 10 warm |

## Verification
The asserting edges are asynchronous, so the bench checks them 1 ns after it lowers an input, before any clock edge. The releases are due on fixed rising edges: the resets on the second edge after the input rises, `cause` on the third edge, and `ext_rst_n` on the edge that takes the write. The bench drives every input on a falling edge and counts falling edges from there. For each result it checks the falling edge just before the due edge, where the old value must still hold, and the falling edge just after, where the new value must appear.

// File: rtl/rstseq_pkg.sv
// Package: shared types and constants for the reset sequencing controller.
// Assumes: the cause encoding below is visible to software and must not move.
package rstseq_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_POR  = 2'b01,
        CAUSE_WARM = 2'b10
    } cause_e;
endpackage

// File: rtl/rstseq_combine.sv
// Module: rstseq_combine
// Forms the raw asynchronous reset terms for each domain from the two requests.
// Assumes: both requests are active low and may change at any time.
module rstseq_combine (
    input  logic por_n,
    input  logic warm_n,
    output logic mod_arst_n,
    output logic jtag_arst_n
);
    // Module domain: reset by either request; test-access domain: power-on only.
    always_comb begin
        mod_arst_n  = por_n & warm_n;
        jtag_arst_n = por_n;
    end
endmodule

// File: rtl/rstseq_sync.sv
// Module: rstseq_sync
// Reset synchroniser: asserts its output at once, releases it after STAGES edges.
// Assumes: STAGES >= 2; clk runs while the release is in progress.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_out_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain on a request.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_out_n = chain_q[STAGES-1];

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_out_n) |-> $past(arst_n, STAGES)); // R3
endmodule

// File: rtl/rstseq_ctl.sv
// Module: rstseq_ctl
// Holds the external-reset release bit and the reset cause field.
// Assumes: mod_rst_n and jtag_rst_n come from rstseq_sync instances
// (asynchronous assert, synchronous release on clk).
module rstseq_ctl
    import rstseq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int REL_BIT   = 0
) (
    input  logic              clk,
    input  logic              mod_rst_n,
    input  logic              jtag_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ext_rst_n,
    output logic [1:0]        cause
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic   rel_q;
    logic   hit;
    logic   mod_d;
    logic   por_pend;
    cause_e cause_q;

    // Decode a write of one to the release bit.
    assign hit = wr_en && (wr_addr == CTRL_A) && wr_data[REL_BIT];

    // Sticky release bit, cleared by any module reset.
    always_ff @(posedge clk or negedge mod_rst_n) begin
        if (!mod_rst_n)  rel_q <= 1'b0;
        else if (hit)    rel_q <= 1'b1;
    end

    // Cause field: cleared only by power-on, updated when the modules come out of reset.
    always_ff @(posedge clk or negedge jtag_rst_n) begin
        if (!jtag_rst_n) begin
            cause_q  <= CAUSE_NONE;
            por_pend <= 1'b1;
            mod_d    <= 1'b0;
        end else begin
            mod_d <= mod_rst_n;
            if (mod_rst_n && !mod_d) begin
                cause_q  <= por_pend ? CAUSE_POR : CAUSE_WARM;
                por_pend <= 1'b0;
            end
        end
    end

    assign ext_rst_n = rel_q;
    assign cause     = cause_q;

    AST_REL_STICKY: assert property (@(posedge clk) disable iff (!mod_rst_n)
        rel_q |=> rel_q); // R5
    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!jtag_rst_n)
        cause_q != 2'b11); // R7

    // While the modules are held in reset, the release bit stays cleared.
    always @(posedge clk) begin
        if (mod_rst_n === 1'b0) AST_EXT_HELD: assert (rel_q !== 1'b1); // R9
    end
endmodule

// File: rtl/rstseq_top.sv
// Module: rstseq_top
// Reset sequencing controller: combines the power-on and warm requests, synchronises
// the release of each reset, and gates the external reset by a software release bit.
// Assumes: clk is the free-running reference clock and is present during reset.
module rstseq_top #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_ADDR   = 0,
    parameter int REL_BIT     = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mod_rst_n,
    output logic              jtag_rst_n,
    output logic              ext_rst_n,
    output logic [1:0]        cause
);
    localparam int N_DOM = 2;

    logic [N_DOM-1:0] arst_n;
    logic [N_DOM-1:0] srst_n;

    rstseq_combine u_comb (
        .por_n       (por_n),
        .warm_n      (warm_n),
        .mod_arst_n  (arst_n[0]),
        .jtag_arst_n (arst_n[1])
    );

    // One synchroniser per reset domain.
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .arst_n    (arst_n[d]),
            .rst_out_n (srst_n[d])
        );
    end

    assign mod_rst_n  = srst_n[0];
    assign jtag_rst_n = srst_n[1];

    rstseq_ctl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .REL_BIT   (REL_BIT)
    ) u_ctl (
        .clk        (clk),
        .mod_rst_n  (mod_rst_n),
        .jtag_rst_n (jtag_rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_rst_n  (ext_rst_n),
        .cause      (cause)
    );

    // Requests seen at an edge must already hold the matching outputs low.
    always @(posedge clk) begin
        if (por_n === 1'b0)
            AST_POR_ALL_LOW: assert (jtag_rst_n === 1'b0 && mod_rst_n === 1'b0 && ext_rst_n === 1'b0); // R1
        if (warm_n === 1'b0)
            AST_WARM_LOW: assert (mod_rst_n === 1'b0 && ext_rst_n === 1'b0); // R2
    end
endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
    localparam int ADDR_W       = 4;
    localparam int DATA_W       = 8;
    localparam int POR_MIN_CYC  = 2700;
    localparam int WATCHDOG_CYC = 200000;

    // Write vectors after power-on: {addr, data, expected ext_rst_n}.
    localparam logic [12:0] WR_TBL [0:5] = '{
        {4'h1, 8'h01, 1'b0},
        {4'h0, 8'h00, 1'b0},
        {4'h0, 8'hFE, 1'b0},
        {4'h0, 8'h01, 1'b1},
        {4'h0, 8'h00, 1'b1},
        {4'h2, 8'hFF, 1'b1}
    };

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              warm_n = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              mod_rst_n, jtag_rst_n, ext_rst_n;
    logic [1:0]        cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    rstseq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mod_rst_n(mod_rst_n),
        .jtag_rst_n(jtag_rst_n), .ext_rst_n(ext_rst_n), .cause(cause)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic outs(input string req, input logic m, input logic j, input logic e);
        chk(req, "mod_rst_n", {7'd0, mod_rst_n}, {7'd0, m});
        chk(req, "jtag_rst_n", {7'd0, jtag_rst_n}, {7'd0, j});
        chk(req, "ext_rst_n", {7'd0, ext_rst_n}, {7'd0, e});
    endtask

    task automatic write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        // Reset state: power-on held from time zero (R1, R7).
        #1;
        outs("R1", 1'b0, 1'b0, 1'b0);
        chk("R7", "cause during power-on", {6'd0, cause}, 8'h00);
        repeat (POR_MIN_CYC) @(negedge clk);
        outs("R1", 1'b0, 1'b0, 1'b0);

        // Release power-on and count edges (R3, R4, R7).
        por_n = 1'b1;
        @(negedge clk);
        outs("R3", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        outs("R3", 1'b1, 1'b1, 1'b0);
        chk("R7", "cause before update", {6'd0, cause}, 8'h00);
        @(negedge clk);
        chk("R7", "cause after power-on", {6'd0, cause}, 8'h01);
        chk("R4", "ext held after release", {7'd0, ext_rst_n}, 8'h00);

        // Table of writes (R4, R5).
        for (int i = 0; i < 6; i++) begin
            write(WR_TBL[i][12:9], WR_TBL[i][8:1]);
            chk(WR_TBL[i][0] ? "R4" : "R5", $sformatf("ext after write %0d", i),
                {7'd0, ext_rst_n}, {7'd0, WR_TBL[i][0]});
        end

        // Warm reset: modules and external low, test-access untouched (R2, R7, R9).
        @(negedge clk);
        warm_n = 1'b0;
        #1;
        outs("R2", 1'b0, 1'b1, 1'b0);
        chk("R7", "cause kept during warm", {6'd0, cause}, 8'h01);
        write(4'h0, 8'h01);
        chk("R9", "write during reset", {7'd0, ext_rst_n}, 8'h00);
        warm_n = 1'b1;
        @(negedge clk);
        chk("R3", "mod one edge after warm", {7'd0, mod_rst_n}, 8'h00);
        @(negedge clk);
        outs("R6", 1'b1, 1'b1, 1'b0);
        chk("R7", "cause before warm update", {6'd0, cause}, 8'h01);
        @(negedge clk);
        chk("R7", "cause after warm", {6'd0, cause}, 8'h02);
        chk("R9", "ext still held", {7'd0, ext_rst_n}, 8'h00);
        write(4'h0, 8'h81);
        chk("R4", "ext after warm release write", {7'd0, ext_rst_n}, 8'h01);

        // Power-on clears cause; both requests together act as power-on (R1, R7, R8).
        @(negedge clk);
        por_n = 1'b0;
        warm_n = 1'b0;
        #1;
        outs("R8", 1'b0, 1'b0, 1'b0);
        chk("R7", "cause cleared by power-on", {6'd0, cause}, 8'h00);
        repeat (20) @(negedge clk);
        por_n = 1'b1;
        warm_n = 1'b1;
        repeat (2) @(negedge clk);
        outs("R6", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8", "cause after both", {6'd0, cause}, 8'h01);

        // Warm held after power-on release: test-access leaves reset alone (R3).
        @(negedge clk);
        warm_n = 1'b0;
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3", "jtag released under warm", {7'd0, jtag_rst_n}, 8'h01);
        chk("R2", "mod held under warm", {7'd0, mod_rst_n}, 8'h00);
        warm_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7", "power-on then warm", {6'd0, cause}, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule